// File: doc/BRIEF.md
# Cartridge Bus Wait-State Generator

This block works out how many cycles one access on a CPU memory bus costs and runs the handshake for it. A 16-bit wait-control word sets the first-access and sequential-access waits for three cartridge windows and for the save-memory window. It also holds a prefetch enable. Work RAM on the external bus has fixed waits. Every other region costs no wait at all.

A request gives a 4-bit region number, a width (16-bit or 32-bit), a sequential flag, a direction, an instruction-fetch flag and a burst word count. When the block is ready, the request is accepted in that cycle. The block then holds `ready` low for exactly the computed cost and raises `done` for one cycle as `ready` returns. A new request may be accepted in that same `done` cycle. The memories, the prefetch buffer contents and bus arbitration lie outside the block; it models only the cycle cost and the handshake.

Top module: `cart_wait_gen`

## Requirements
- R1: After reset `ready` is 1, `done` is 0 and the control word is 0x0000, which gives window 0 a 16-bit first-access wait of 4 and a sequential wait of 2.
- R2: Regions 8–9 are window 0, 10–11 window 1 and 12–13 window 2. The window first-access codes sit in control bits 3:2 (window 0), 6:5 (window 1) and 9:8 (window 2). Codes 0, 1, 2 and 3 give 16-bit first-access waits of 4, 3, 2 and 8.
- R3: The sequential bits are bit 4 (window 0), bit 7 (window 1) and bit 10 (window 2). A bit value of 1 gives a 16-bit sequential wait of 1. A bit value of 0 gives 2, 4 or 8 for windows 0, 1 and 2.
- R4: For a cartridge window, the 32-bit sequential wait is twice the 16-bit sequential wait plus 1. The 32-bit first-access wait is the 16-bit first-access wait plus 1 plus the 16-bit sequential wait.
- R5: Regions 14–15 are save memory. Control bits 1:0 select its wait with the same 4/3/2/8 code mapping, for both sequential and non-sequential 16-bit accesses. Its 32-bit wait is twice that value plus 1.
- R6: Region 2 (external work RAM) always waits 2 for a 16-bit access and 5 for a 32-bit access, whatever the control word holds.
- R7: Every region from 0 to 7 other than 2 has zero wait.
- R8: A single access (burst count 0 or 1) costs 2 plus its wait for a load and 1 plus its wait for a store. The wait is picked by width and by the sequential flag.
- R9: A burst count N ≥ 2 costs (1 + 32-bit first-access wait) + (N−1)·(1 + 32-bit sequential wait), whatever the width flag.
- R10: With control bit 14 set, instruction fetches from regions 8–13 use zero waits. Data accesses there, and fetches from other regions, keep their programmed waits.
- R11: After acceptance `ready` stays low for exactly the cost in cycles. `done` is a one-cycle pulse in the first cycle with `ready` high again. Requests presented while `ready` is low are ignored.
- R12: A control write in the same cycle as an acceptance does not change that access's cost. It governs only accesses accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the wait-control word |
| cfg_wdata | input | 16 | New wait-control word |
| req_valid | input | 1 | Access request |
| req_region | input | 4 | Region number of the access |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 8/16-bit |
| req_seq | input | 1 | 1 = sequential access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_burst | input | BURST_W | Burst word count (0 or 1 = single access) |
| ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle pulse when the access ends |

## Verification
Two events can land on the same clock edge. A control-word write can coincide with the acceptance of a request. The completion pulse of one access can coincide with the acceptance of the next. The bench drives both at once: it issues every access back to back from the `done` cycle, and it raises `cfg_we` alongside `req_valid`. It measures the low time of `ready` for each access. A concurrent write must leave the current cost on the old settings and move the following one to the new settings.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
   localparam int WAIT_W = 5;

   typedef struct packed {
      logic [WAIT_W-1:0] n16;
      logic [WAIT_W-1:0] s16;
      logic [WAIT_W-1:0] n32;
      logic [WAIT_W-1:0] s32;
   } wait_set_t;

   localparam logic [3:0] REGION_XRAM = 4'd2;
   localparam int         PF_BIT      = 14;

   // 2-bit first-access code to wait cycles
   function automatic logic [WAIT_W-1:0] code_to_wait(input logic [1:0] code);
      case (code)
         2'd0:    return WAIT_W'(4);
         2'd1:    return WAIT_W'(3);
         2'd2:    return WAIT_W'(2);
         default: return WAIT_W'(8);
      endcase
   endfunction

   // lsb of the first-access field for cartridge window w
   function automatic int win_first_lsb(input int w);
      return (w == 0) ? 2 : ((w == 1) ? 5 : 8);
   endfunction
endpackage

// File: rtl/cwg_wait_table.sv
module cwg_wait_table
   import cwg_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int N_WIN   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic [3:0]       region,
   input  logic             fetch,
   output wait_set_t        waits,
   output logic             pf_hit
);
   localparam int WIN_BASE = 4; // region[3:1] of window 0

   initial begin : param_chk
      assert (CFG_W >= 16 && N_WIN == 3) else $error("cwg_wait_table: bad parameters");
   end

   logic [CFG_W-1:0] cfg_q;
   wait_set_t        win_set [N_WIN];
   wait_set_t        sram_set;
   logic [N_WIN-1:0] win_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      localparam int FL = win_first_lsb(w);
      logic [WAIT_W-1:0] n16, s16;
      always_comb begin
         n16 = code_to_wait(cfg_q[FL +: 2]);
         s16 = cfg_q[FL+2] ? WAIT_W'(1) : WAIT_W'(2 << w);
         win_set[w].n16 = n16;
         win_set[w].s16 = s16;
         win_set[w].n32 = n16 + s16 + WAIT_W'(1);
         win_set[w].s32 = {s16[WAIT_W-2:0], 1'b1};
      end
      assign win_hit[w] = (region[3:1] == 3'(WIN_BASE + w));
   end

   always_comb begin
      logic [WAIT_W-1:0] sw;
      sw = code_to_wait(cfg_q[1:0]);
      sram_set.n16 = sw;
      sram_set.s16 = sw;
      sram_set.n32 = {sw[WAIT_W-2:0], 1'b1};
      sram_set.s32 = {sw[WAIT_W-2:0], 1'b1};
   end

   assign pf_hit = cfg_q[PF_BIT] && fetch && (|win_hit);

   always_comb begin
      waits = '0;
      for (int w = 0; w < N_WIN; w++)
         if (win_hit[w]) waits = win_set[w];
      if (region[3:1] == 3'b111)
         waits = sram_set;
      if (region == REGION_XRAM) begin
         waits.n16 = WAIT_W'(2);
         waits.s16 = WAIT_W'(2);
         waits.n32 = WAIT_W'(5);
         waits.s32 = WAIT_W'(5);
      end
      if (pf_hit) waits = '0;
   end

   // R12
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/cwg_cost_calc.sv
module cwg_cost_calc
   import cwg_pkg::*;
#(
   parameter int BURST_W = 8,
   parameter int CNT_W   = 16
) (
   input  wait_set_t          waits,
   input  logic               wide,
   input  logic               seq,
   input  logic               write,
   input  logic [BURST_W-1:0] burst,
   output logic [CNT_W-1:0]   cost
);
   localparam int MAX_COST = 18 * (2 ** BURST_W);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);

   initial begin : width_chk
      assert ($clog2(MAX_COST + 1) <= CNT_W) else $error("cwg_cost_calc: CNT_W too narrow");
   end

   logic [WAIT_W-1:0] wsel;
   logic [CNT_W-1:0]  single_c, first_c, each_c, rest_c;
   logic              is_burst;

   always_comb begin
      if (wide) wsel = seq ? waits.s32 : waits.n32;
      else      wsel = seq ? waits.s16 : waits.n16;
      single_c = (write ? C_ONE : C_TWO) + CNT_W'(wsel);
      first_c  = C_ONE + CNT_W'(waits.n32);
      each_c   = C_ONE + CNT_W'(waits.s32);
      rest_c   = CNT_W'(burst - 1'b1) * each_c;
      is_burst = (burst > BURST_W'(1));
      cost     = is_burst ? (first_c + rest_c) : single_c;
   end
endmodule

// File: rtl/cwg_handshake.sv
module cwg_handshake #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] cost,
   output logic             ready,
   output logic             done
);
   logic             busy;
   logic [CNT_W-1:0] cnt;

   assign ready = !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               busy <= 1'b1;
               cnt  <= cost - CNT_W'(1);
            end
         end else if (cnt == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> !ready);
   // R11
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && ready));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   cost_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |-> (cost != '0));
endmodule

// File: rtl/cart_wait_gen.sv
module cart_wait_gen
   import cwg_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int BURST_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   input  logic               req_valid,
   input  logic [3:0]         req_region,
   input  logic               req_wide,
   input  logic               req_seq,
   input  logic               req_write,
   input  logic               req_fetch,
   input  logic [BURST_W-1:0] req_burst,
   output logic               ready,
   output logic               done
);
   wait_set_t        waits;
   logic             pf_hit;
   logic [CNT_W-1:0] cost;

   cwg_wait_table #(.CFG_W(CFG_W), .N_WIN(3)) u_tab (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .region(req_region), .fetch(req_fetch), .waits(waits), .pf_hit(pf_hit)
   );

   cwg_cost_calc #(.BURST_W(BURST_W), .CNT_W(CNT_W)) u_cost (
      .waits(waits), .wide(req_wide), .seq(req_seq), .write(req_write),
      .burst(req_burst), .cost(cost)
   );

   cwg_handshake #(.CNT_W(CNT_W)) u_hs (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cost(cost),
      .ready(ready), .done(done)
   );

   // R10
   pf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_hit && req_valid && ready && req_burst <= BURST_W'(1))
         |-> (cost == (req_write ? CNT_W'(1) : CNT_W'(2))));
endmodule

// File: tb/cart_wait_gen_tb.sv
`timescale 1ns/1ps
module cart_wait_gen_tb;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [15:0]   cfg_wdata = '0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_region = '0;
   logic          req_wide = 1'b0, req_seq = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
   logic [BW-1:0] req_burst = '0;
   logic          ready, done;

   int n_tests = 0;
   int n_fail  = 0;
   logic [15:0] cfg_model = '0;

   always #2.5 clk = ~clk;

   cart_wait_gen #(.CFG_W(16), .BURST_W(BW), .CNT_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
      .req_seq(req_seq), .req_write(req_write), .req_fetch(req_fetch),
      .req_burst(req_burst), .ready(ready), .done(done)
   );

   function automatic int first_w(input int code);
      case (code & 3)
         0: return 4;
         1: return 3;
         2: return 2;
         default: return 8;
      endcase
   endfunction

   function automatic int exp_cost(input logic [15:0] c, input int rg, input bit wd,
                                   input bit sq, input bit wr, input bit fe, input int bu);
      int n16, s16, n32, s32, w, lsb, ws;
      n16 = 0; s16 = 0; n32 = 0; s32 = 0;
      if (rg >= 8 && rg <= 13) begin
         w   = (rg - 8) / 2;
         lsb = (w == 0) ? 2 : ((w == 1) ? 5 : 8);
         n16 = first_w(int'(c[lsb +: 2]));
         s16 = c[lsb+2] ? 1 : (2 << w);
         n32 = n16 + 1 + s16;
         s32 = 2 * s16 + 1;
         if (c[14] && fe) begin n16 = 0; s16 = 0; n32 = 0; s32 = 0; end
      end else if (rg >= 14) begin
         n16 = first_w(int'(c[1:0])); s16 = n16;
         n32 = 2 * n16 + 1; s32 = n32;
      end else if (rg == 2) begin
         n16 = 2; s16 = 2; n32 = 5; s32 = 5;
      end
      if (bu > 1) return (1 + n32) + (bu - 1) * (1 + s32);
      ws = wd ? (sq ? s32 : n32) : (sq ? s16 : n16);
      return (wr ? 1 : 2) + ws;
   endfunction

   function automatic string classify(input logic [15:0] c, input int rg, input bit wd,
                                      input bit sq, input bit fe, input int bu);
      if (bu > 1) return "R9";
      if (c[14] && fe && rg >= 8 && rg <= 13) return "R10";
      if (rg >= 14) return "R5";
      if (rg == 2) return "R6";
      if (rg < 8) return "R7";
      if (wd) return "R4";
      if (sq) return "R3";
      return "R2";
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge where done is seen.
   task automatic run(input string tag, input int rg, input bit wd, input bit sq,
                      input bit wr, input bit fe, input int bu,
                      input bit do_cfg, input logic [15:0] new_cfg);
      int exp, n;
      string t;
      exp = exp_cost(cfg_model, rg, wd, sq, wr, fe, bu);
      t = (tag == "") ? classify(cfg_model, rg, wd, sq, fe, bu) : tag;
      req_region = 4'(rg); req_wide = wd; req_seq = sq; req_write = wr;
      req_fetch = fe; req_burst = BW'(bu); req_valid = 1'b1;
      if (do_cfg) begin cfg_we = 1'b1; cfg_wdata = new_cfg; end
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      if (do_cfg) cfg_model = new_cfg;
      n = 0;
      while (!done && n < 20000) begin
         if (!ready) n++;
         @(negedge clk);
      end
      check(t, n, exp);
   endtask

   task automatic set_cfg(input logic [15:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0; cfg_model = v;
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      int seed, n, dones;
      seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and default window-0 timing
      check("R1 ready", int'(ready), 1);
      check("R1 done", int'(done), 0);
      run("R1", 8, 0, 0, 0, 0, 0, 0, '0);
      run("R1", 9, 0, 1, 0, 0, 0, 0, '0);
      // R2 window 1 code 3 -> 8
      set_cfg(16'h0060);
      run("R2", 10, 0, 0, 0, 0, 0, 0, '0);
      // R3 window 2 sequential bit
      set_cfg(16'h0400);
      run("R3", 12, 0, 1, 1, 0, 0, 0, '0);
      set_cfg(16'h0000);
      run("R3", 13, 0, 1, 1, 0, 0, 0, '0);
      // R4 window 0 code 2, 32-bit
      set_cfg(16'h0008);
      run("R4", 8, 1, 0, 0, 0, 0, 0, '0);
      run("R4", 8, 1, 1, 0, 0, 0, 0, '0);
      // R5 save memory code 3
      set_cfg(16'h0003);
      run("R5", 14, 0, 0, 0, 0, 0, 0, '0);
      run("R5", 15, 1, 1, 0, 0, 0, 0, '0);
      // R6 external work RAM ignores config
      set_cfg(16'hFFFF);
      run("R6", 2, 1, 0, 1, 0, 0, 0, '0);
      run("R6", 2, 0, 1, 0, 0, 0, 0, '0);
      // R7 / R8 zero-wait regions
      run("R7", 3, 1, 0, 0, 0, 0, 0, '0);
      run("R8", 0, 0, 0, 1, 0, 0, 0, '0);
      // R9 burst
      set_cfg(16'h0000);
      run("R9", 8, 0, 0, 0, 0, 4, 0, '0);
      // R10 prefetch
      set_cfg(16'h4000);
      run("R10", 8, 0, 0, 0, 1, 0, 0, '0);
      run("R10", 8, 0, 0, 0, 0, 0, 0, '0);
      run("R10", 12, 1, 0, 0, 1, 3, 0, '0);
      run("R10", 14, 0, 0, 0, 1, 0, 0, '0);
      // R12 concurrent write: this access keeps old settings, next uses new
      set_cfg(16'h0000);
      run("R12", 10, 0, 0, 0, 0, 0, 1, 16'h0060);
      run("R12", 10, 0, 0, 0, 0, 0, 0, '0);
      // R11 requests while busy are ignored (region 2 load: cost 4)
      @(negedge clk);
      req_region = 4'd2; req_wide = 0; req_seq = 0; req_write = 0; req_fetch = 0;
      req_burst = '0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_region = 4'd15; req_wide = 1; req_burst = BW'(9); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 2; dones = 0;
      while (!done && n < 100) begin
         if (!ready) n++;
         @(negedge clk);
      end
      check("R11 busy length", n, 4);
      repeat (6) begin
         @(negedge clk);
         if (done) dones++;
         if (!ready) dones++;
      end
      check("R11 no extra access", dones, 0);
      // constrained random, back to back
      for (int i = 0; i < 400; i++) begin
         int rg, bu;
         bit dc;
         rg = int'($urandom_range(0, 15));
         bu = ($urandom_range(0, 4) == 0) ? int'($urandom_range(2, 20)) : int'($urandom_range(0, 1));
         dc = ($urandom_range(0, 5) == 0);
         run("", rg, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), bu,
             dc, 16'($urandom));
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule